// File: doc/BRIEF.md
# Full-Duplex Synchronous Serial Port

An 8-bit clocked serial port that sends and receives one byte at a time. It transmits on a serial data output and receives on a serial data input in the same clock cycles. Software drives it through a small register bus with four byte registers: control, status, a transmit buffer and a receive buffer. The serial clock is either made on chip by dividing the system clock, or taken from an external clock pin. The external pin passes through a synchronizer, and its edges are detected in the system clock domain. Each received byte raises a one-cycle interrupt.

With the on-chip clock the port holds the line clock high between bytes. It stays there until software has both read the byte just received and supplied the next byte to send. This flow control stops either buffer from being overwritten without any error reporting.

Register map (`bus_addr`):
- 0: control, read and write. Bits [1:0] are the mode, bit 2 selects the external clock, bit 3 selects LSB-first order and bit 7 is start.
- 1: status, read only. Bit 0 is transmit buffer empty, bit 1 is receive full, bit 2 is busy and bit 3 is shifting. All other bits read 0.
- 2: transmit buffer.
- 3: receive buffer.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the status register reads 0x01 (transmit buffer empty, nothing received, idle, not shifting), `sck_o` is high and `irq` is low.
- R2: Writing the transmit buffer (address 2) clears status bit 0. The bit returns to 1 when the first falling serial clock edge of a byte loads that data into the shift register.
- R3: Reading the receive buffer (address 3) clears status bit 1.
- R4: With control bit 3 at 0, bits are sent on `sdo` and assembled from `sdi` MSB first.
- R5: With control bit 3 at 1, both directions are LSB first.
- R6: `sdo` changes only on a falling serial clock edge. `sdi` is sampled on a rising edge.
- R7: After the eighth rising edge of a byte, the received byte appears in the receive buffer. Status bit 1 and `irq` are set in the same cycle.
- R8: Status bit 3 (shifting) is 1 from the first falling edge of a byte until its eighth falling edge.
- R9: With the internal clock (control bit 2 at 0), `sck_o` stays high between bytes while the transmit buffer is empty or the receive buffer is unread.
- R10: Once both the transmit write and the receive read have happened, in either order, the internal clock falls again within one serial clock period.
- R11: Status bit 2 (busy) rises with the first falling edge after start. It clears when start (control bit 7) is 0 and no byte is in progress.
- R12: Serial operation runs only when the mode field holds binary 10 and start is 1; other modes leave the buffers and flags unchanged. `sck_oe` is 1 only when the internal clock is selected.
- R13: `irq` is a single-cycle pulse, exactly one per received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on address 3) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| irq | output | 1 | Received-byte interrupt pulse |
| sck_i | input | 1 | External serial clock |
| sck_o | output | 1 | Internal serial clock output |
| sck_oe | output | 1 | Serial clock output enable |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |

## Verification
The hardest situation to reach is the automatic wait with only one of its two release conditions met. Reaching it needs a full internal-clock exchange to finish first. The bench loops `sdo` back to `sdi` so that internal-clock bytes complete on their own. After a byte completes, the bench performs only the transmit write, or only the receive read, and watches `sck_o` stay high over many serial periods. It then performs the missing access and measures how long the clock takes to fall. The external-clock tests drive `sck_i` one edge at a time, so every `sdo` bit and each flag can be checked between edges.

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       sdi,
  output logic       sdo
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [7:0] ctrl, txbuf, rxbuf, tsh, rsh;
  logic       tx_empty, rx_full, busy, shifting, sck_int, sdo_r;
  logic [3:0] bitcnt;
  logic [2:0] rcnt;
  logic [CW-1:0] div_cnt;
  logic [2:0] sck_s;
  logic [1:0] sdi_s;

  wire full_dup = ctrl[1:0] == 2'b10;
  wire ext      = ctrl[2];
  wire lsb      = ctrl[3];
  wire start    = ctrl[7];
  wire en       = start && full_dup;
  wire wr_tx    = bus_wr && bus_addr == 2'd2;

  wire run   = !ext && full_dup && (bitcnt != 0 || (start && !tx_empty && !rx_full));
  wire tick  = run && div_cnt == CW'(DIV - 1);
  wire fall_raw = ext ? (sck_s[2] && !sck_s[1]) : (tick && sck_int);
  wire rise_raw = ext ? (!sck_s[2] && sck_s[1]) : (tick && !sck_int);
  wire fall_ok  = (bitcnt == 0) ? en : (bitcnt < 4'd8);
  wire fall_ev  = fall_raw && fall_ok;
  wire rise_ev  = rise_raw && bitcnt != 0;
  wire [7:0] rnext = lsb ? {sdi_s[1], rsh[7:1]} : {rsh[6:0], sdi_s[1]};

  assign sck_o  = sck_int;
  assign sck_oe = !ext;
  assign sdo    = sdo_r;

  always_comb
    case (bus_addr)
      2'd0:    bus_rdata = ctrl;
      2'd1:    bus_rdata = {4'b0, shifting, busy, rx_full, tx_empty};
      2'd2:    bus_rdata = txbuf;
      default: bus_rdata = rxbuf;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s <= 3'b111; sdi_s <= 2'b00; div_cnt <= '0; sck_int <= 1'b1;
    end else begin
      sck_s <= {sck_s[1:0], sck_i};
      sdi_s <= {sdi_s[0], sdi};
      div_cnt <= (!run || tick) ? '0 : div_cnt + 1'b1;
      if (tick) sck_int <= !sck_int;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= '0; txbuf <= '0; rxbuf <= '0; tsh <= '0; rsh <= '0;
      tx_empty <= 1'b1; rx_full <= 1'b0; busy <= 1'b0; shifting <= 1'b0;
      sdo_r <= 1'b1; bitcnt <= '0; rcnt <= '0; irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (bus_wr && bus_addr == 2'd0) ctrl <= bus_wdata;
      if (bus_rd && bus_addr == 2'd3) rx_full <= 1'b0;
      if (bitcnt == 0 && !start) busy <= 1'b0;
      if (fall_ev) begin
        if (bitcnt == 0) begin
          sdo_r    <= lsb ? txbuf[0] : txbuf[7];
          tsh      <= lsb ? txbuf >> 1 : txbuf << 1;
          tx_empty <= 1'b1;
          shifting <= 1'b1;
          busy     <= 1'b1;
        end else begin
          sdo_r <= lsb ? tsh[0] : tsh[7];
          tsh   <= lsb ? tsh >> 1 : tsh << 1;
          if (bitcnt == 4'd7) shifting <= 1'b0;
        end
        bitcnt <= bitcnt + 1'b1;
      end
      if (rise_ev) begin
        rsh <= rnext;
        rcnt <= rcnt + 1'b1;
        if (rcnt == 3'd7) begin
          rxbuf <= rnext; rx_full <= 1'b1; irq <= 1'b1; bitcnt <= '0;
        end
      end
      if (wr_tx) begin
        txbuf <= bus_wdata; tx_empty <= 1'b0;
      end
    end

  p_irq_rxf_r7: assert property (@(posedge clk) disable iff (!rst_n) irq |-> rx_full);
  p_irq_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
  p_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext && bitcnt == 0) |-> sck_o);
  p_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext && bitcnt == 0 && (tx_empty || rx_full)) |=> $stable(sck_o));
  p_sdo_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ext) && !$stable(sdo)) |-> $fell(sck_o));
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> shifting);
  p_shift_busy_r11: assert property (@(posedge clk) disable iff (!rst_n) shifting |-> busy);
  p_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_dup && bitcnt == 0) |=> !$rose(shifting));
endmodule

// File: tb/sim_sync_serial_port.sv
module sim_sync_serial_port;
  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, sck_i = 1, sdi_d = 0, loop = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic irq, sck_o, sck_oe, sdo;
  wire sdi_w = loop ? sdo : sdi_d;
  int checks = 0, fails = 0, irq_seen = 0;
  logic [7:0] exp_q[$];
  logic [7:0] last_exp = 0;

  always #5 clk = ~clk;

  sync_serial_port #(.DIV(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sck_i(sck_i),
    .sck_o(sck_o), .sck_oe(sck_oe), .sdi(sdi_w), .sdo(sdo));

  always @(negedge clk)
    if (rst_n && irq) begin
      irq_seen++;
      if (exp_q.size() > 0) last_exp = exp_q.pop_front();
    end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic ext_byte(logic [7:0] tx, logic [7:0] rxv, logic lsbf, string req);
    logic [7:0] s;
    exp_q.push_back(rxv);
    for (int i = 0; i < 8; i++) begin
      int k = lsbf ? i : 7 - i;
      sck_i = 0; sdi_d = rxv[k];
      repeat (8) @(negedge clk);
      chk({req, " sdo bit"}, {7'b0, sdo}, {7'b0, tx[k]});
      if (i == 0) begin
        rd(1, s); chk("R2 R8 R11 first fall", s & 8'h0D, 8'h0D);
      end
      if (i == 7) begin
        rd(1, s); chk("R8 shifting after eighth fall", {7'b0, s[3]}, 8'h00);
      end
      sck_i = 1;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic wait_rx;
    logic [7:0] s;
    for (int n = 0; n < 400; n++) begin
      rd(1, s);
      if (s[1]) break;
    end
  endtask

  task automatic hold_high(string req);
    int falls = 0;
    repeat (60) begin
      @(negedge clk);
      if (!sck_o) falls++;
    end
    chk(req, 8'(falls), 8'h00);
  endtask

  task automatic resume(string req);
    int n = 0;
    while (sck_o && n < 20) begin
      @(negedge clk); n++;
    end
    chk(req, {7'b0, n <= 10}, 8'h01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(1, s); chk("R1 status", s, 8'h01);
    chk("R1 sck_o/irq", {6'b0, sck_o, irq}, 8'h02);

    wr(2, 8'hA5);
    rd(1, s); chk("R2 tx write clears empty", {7'b0, s[0]}, 8'h00);
    wr(0, 8'h86);
    chk("R12 sck_oe external", {7'b0, sck_oe}, 8'h00);
    repeat (10) @(negedge clk);
    rd(1, s); chk("R11 busy before first fall", {7'b0, s[2]}, 8'h00);
    ext_byte(8'hA5, 8'h3C, 0, "R4 R6");
    rd(1, s); chk("R7 rx full", {7'b0, s[1]}, 8'h01);
    rd(3, s); chk("R4 R7 rx byte", s, last_exp);
    rd(1, s); chk("R3 read clears full", {7'b0, s[1]}, 8'h00);
    chk("R13 one irq", 8'(irq_seen), 8'h01);

    wr(0, 8'h8E);
    wr(2, 8'h4B);
    ext_byte(8'h4B, 8'hD2, 1, "R5 R6");
    rd(3, s); chk("R5 rx byte lsb first", s, last_exp);
    wr(0, 8'h06);
    rd(1, s); chk("R11 busy clears after stop", {7'b0, s[2]}, 8'h00);

    wr(0, 8'h85);
    wr(2, 8'h11);
    repeat (4) begin
      sck_i = 0; repeat (8) @(negedge clk);
      sck_i = 1; repeat (8) @(negedge clk);
    end
    rd(1, s); chk("R12 wrong mode no activity", s, 8'h00);
    chk("R12 no irq", 8'(irq_seen), 8'h02);

    loop = 1;
    wr(0, 8'h02);
    chk("R12 sck_oe internal", {7'b0, sck_oe}, 8'h01);
    wr(2, 8'h96); exp_q.push_back(8'h96);
    wr(0, 8'h82);
    wait_rx();
    hold_high("R9 wait with nothing done");
    wr(2, 8'h5A); exp_q.push_back(8'h5A);
    hold_high("R9 wait after tx write only");
    rd(3, s); chk("R4 R10 internal rx byte", s, 8'h96);
    resume("R10 resume after read");
    wait_rx();
    rd(3, s); chk("R10 second byte", s, 8'h5A);
    hold_high("R9 wait after rx read only");
    wr(2, 8'hC3); exp_q.push_back(8'hC3);
    resume("R10 resume after write");
    wait_rx();
    rd(3, s); chk("R10 third byte", s, last_exp);
    chk("R10 third byte value", s, 8'hC3);
    wr(0, 8'h02);
    rd(1, s); chk("R11 busy clears internal", {7'b0, s[2]}, 8'h00);
    chk("R13 irq per byte", 8'(irq_seen), 8'h05);
    chk("R9 sck parked high", {7'b0, sck_o}, 8'h01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule